// File: doc/BRIEF.md
# MDIO Management Frame Master

This block carries out single PHY management transactions on a two-wire serial management link: a clock output `mdc` and one bidirectional data line, presented as a driven value `mdio_o`, an output enable `mdio_oe` and a sampled input `mdio_i`. A host asks for a read or a write with a one-cycle `req` pulse. The pulse carries a 5-bit PHY address and a 5-bit register address, plus 16 bits of data for a write. The block then runs a fixed sequence. It sends a run of idle ones, then the command frame. For a read only, it releases the line and captures the returned data. It ends with another run of idle ones and then pulses `done`.

The state machine has five named states. `ST_IDLE` waits for a request. `ST_PRE` sends the leading ones. `ST_CMD` shifts out the command word. `ST_CAP` is used by reads only; the line is released and data bits are captured. `ST_POST` sends the trailing ones. The transitions are:
- ST_IDLE to ST_PRE when a request is accepted.
- ST_PRE to ST_CMD after the last leading one.
- ST_CMD to ST_CAP after the 14th bit of a read.
- ST_CMD to ST_POST after the 32nd bit of a write.
- ST_CAP to ST_POST after the 18th captured bit.
- ST_POST to ST_IDLE after the last trailing one, together with `done`.

The management clock is derived from the system clock. The divisor `half_period` is sampled when a request is accepted. Each management clock phase then lasts `half_period`+1 system clocks, and the host picks the divisor that keeps the link within the PHY's rate limit. Each bit period is a low phase followed by a high phase.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever the block is idle, `mdc` is 0, `mdio_oe` is 1, `mdio_o` is 1, `busy` is 0 and `done` is 0. `rd_data` resets to 0.
- R2: A `req` seen while idle is accepted at that clock edge, and `busy` is 1 from the next cycle on. The transaction starts with 32 bit periods of `mdio_o`=1 with the line driven.
- R3: The command word, sent MSB first, is laid out as follows. Bits 31:30 are 01. Bits 29:28 are the opcode: 10 for a read, 01 for a write. Bits 27:23 are the PHY address and bits 22:18 are the register address. Bits 17:16 are 10. Bits 15:0 are the write data for a write and zero for a read.
- R4: Every management clock phase lasts `half_period`+1 system clocks, with `mdc` low and then high in each bit period. A bit's value on `mdio_o` appears at the start of the low phase and holds through the high phase.
- R5: A write sends all 32 command bits with `mdio_oe`=1.
- R6: A read sends only command bits 31:18, 14 bits in all. It then drops `mdio_oe` for exactly 18 bit periods, beginning with the low phase that follows the 14th bit. `mdio_oe` is 0 at no other time.
- R7: During those 18 periods the block samples `mdio_i` at the last system clock of each low phase, MSB first. `rd_data` returns the last 16 bits received, so the first two are dropped.
- R8: After either kind of transaction the line is driven again and 32 bit periods of ones follow. Then `done` is 1 for exactly one cycle. That is the cycle in which `busy` first reads 0.
- R9: A `req` while `busy` is 1 is ignored. The running transaction's waveform is unchanged, and no further transaction follows it.
- R10: `rd_data` changes only in the cycle `done` is 1 at the end of a read. It holds through later writes and through the next transaction until that one finishes.
- R11: Changing `half_period`, or any request field, during a transaction has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start pulse, accepted only when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| half_period | input | DIV_W | Management clock phase length minus one, in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data from the latest completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, 32-bit idle runs, 14 read command bits and 18 capture bits. It drives `half_period` at run time with values from 0 to 3. A full 96-bit transaction therefore takes at most 768 cycles, so several reads and writes fit in one run. The divisor 0 exercises single-cycle phases and bit periods of only two system clocks. The larger divisors show that the capture point sits at the end of the low phase. The bench also injects a request with a different divisor part way through a read. Because that read uses divisor 3, a change in effective phase length would show up in the cycle-by-cycle comparison.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_CMD,
        ST_CAP,
        ST_POST
    } mdio_state_t;

    localparam int FRAME_W = 32;

    function automatic logic [FRAME_W-1:0] mdio_frame(
        input logic        is_read,
        input logic [4:0]  phy_addr,
        input logic [4:0]  reg_addr,
        input logic [15:0] wdata
    );
        logic [1:0]  opc;
        logic [15:0] payload;
        opc     = is_read ? 2'b10 : 2'b01;
        payload = is_read ? 16'h0000 : wdata;
        return {2'b01, opc, phy_addr, reg_addr, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] half_in,
    input  logic             run,
    output logic             tick
);
    logic [DIV_W-1:0] limit_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            limit_q <= half_in;
            cnt_q   <= '0;
        end else if (run) begin
            if (cnt_q == limit_q) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             din,
    output logic [OUT_W-1:0] data
);
    logic [OUT_W-1:0] sr_q;

    assign data = sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= '0;
        else if (clr)      sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[OUT_W-2:0], din};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W         = 8,
    parameter int PRE_BITS      = 32,
    parameter int POST_BITS     = 32,
    parameter int READ_CMD_BITS = 14,
    parameter int CAP_BITS      = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_read,
    input  logic [4:0]       req_phy,
    input  logic [4:0]       req_reg,
    input  logic [15:0]      req_wdata,
    input  logic [DIV_W-1:0] half_period,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rd_data,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int RD_W     = 16;
    localparam int MAX_A    = (PRE_BITS > POST_BITS) ? PRE_BITS : POST_BITS;
    localparam int MAX_B    = (FRAME_W > CAP_BITS) ? FRAME_W : CAP_BITS;
    localparam int MAX_BITS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    mdio_state_t        state_q;
    logic               ph_q;
    logic [CNT_W-1:0]   bitcnt_q;
    logic [FRAME_W-1:0] sh_q;
    logic               is_rd_q;
    logic               done_q;
    logic [RD_W-1:0]    rd_q;

    logic               accept;
    logic               tick;
    logic [CNT_W-1:0]   bit_limit;
    logic               last_bit;
    logic [RD_W-1:0]    cap_data;

    assign accept   = (state_q == ST_IDLE) && req;
    assign last_bit = (bitcnt_q == bit_limit - 1'b1);

    mdio_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .half_in (half_period),
        .run     (state_q != ST_IDLE),
        .tick    (tick)
    );

    mdio_rx_shift #(.OUT_W(RD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .shift_en ((state_q == ST_CAP) && tick && !ph_q),
        .din      (mdio_i),
        .data     (cap_data)
    );

    always_comb begin
        unique case (state_q)
            ST_PRE:  bit_limit = CNT_W'(PRE_BITS);
            ST_CMD:  bit_limit = is_rd_q ? CNT_W'(READ_CMD_BITS) : CNT_W'(FRAME_W);
            ST_CAP:  bit_limit = CNT_W'(CAP_BITS);
            ST_POST: bit_limit = CNT_W'(POST_BITS);
            default: bit_limit = CNT_W'(1);
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ph_q     <= 1'b0;
            bitcnt_q <= '0;
            sh_q     <= '0;
            is_rd_q  <= 1'b0;
            done_q   <= 1'b0;
            rd_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q  <= ST_PRE;
                ph_q     <= 1'b0;
                bitcnt_q <= '0;
                sh_q     <= mdio_frame(req_read, req_phy, req_reg, req_wdata);
                is_rd_q  <= req_read;
            end else if (tick) begin
                if (!ph_q) begin
                    ph_q <= 1'b1;
                end else begin
                    ph_q <= 1'b0;
                    if (state_q == ST_CMD) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
                    if (!last_bit) begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else begin
                        bitcnt_q <= '0;
                        unique case (state_q)
                            ST_PRE:  state_q <= ST_CMD;
                            ST_CMD:  state_q <= is_rd_q ? ST_CAP : ST_POST;
                            ST_CAP:  state_q <= ST_POST;
                            ST_POST: begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                                if (is_rd_q) rd_q <= cap_data;
                            end
                            default: state_q <= ST_IDLE;
                        endcase
                    end
                end
            end
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                mdc = 1'b0; mdio_o = 1'b1;         mdio_oe = 1'b1;
            end
            ST_CMD: begin
                mdc = ph_q; mdio_o = sh_q[FRAME_W-1]; mdio_oe = 1'b1;
            end
            ST_CAP: begin
                mdc = ph_q; mdio_o = 1'b1;         mdio_oe = 1'b0;
            end
            default: begin
                mdc = ph_q; mdio_o = 1'b1;         mdio_oe = 1'b1;
            end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign rd_data = rd_q;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mdio_oe && mdio_o && !mdc && !(done && busy))); // R1

    AST_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe |-> busy); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done); // R10
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  half_period = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_rd = 16'h0000;

    // expected entries per system clock: {mdc, mdio_o, mdio_oe, rx_bit}
    logic [3:0] expq[$];
    string      tagq[$];

    always #2 clk = ~clk;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .half_period(half_period), .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_bit(input logic v, input logic oe, input logic rx,
                            input int hp, input string tag);
        for (int p = 0; p < 2; p++)
            for (int c = 0; c <= hp; c++) begin
                expq.push_back({p[0], v, oe, rx});
                tagq.push_back(tag);
            end
    endtask

    task automatic build(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input int hp, input logic [17:0] resp);
        logic [31:0] cw;
        cw = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, (rd ? 16'h0 : wd)};
        for (int i = 0; i < 32; i++) push_bit(1'b1, 1'b1, 1'b0, hp, "R2 preamble");
        if (rd) begin
            for (int i = 0; i < 14; i++) push_bit(cw[31-i], 1'b1, 1'b0, hp, "R3/R4/R6 read cmd");
            for (int i = 0; i < 18; i++) push_bit(1'b1, 1'b0, resp[17-i], hp, "R6/R7 capture");
        end else begin
            for (int i = 0; i < 32; i++) push_bit(cw[31-i], 1'b1, 1'b0, hp, "R3/R4/R5 write cmd");
        end
        for (int i = 0; i < 32; i++) push_bit(1'b1, 1'b1, 1'b0, hp, "R8 trailer");
    endtask

    task automatic txn(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] wd, input int hp, input logic [17:0] resp,
                       input bit disturb);
        int idx;
        logic [3:0] e;
        string t;
        @(negedge clk);
        req = 1'b1; req_read = rd; req_phy = phy; req_reg = ra; req_wdata = wd;
        half_period = 8'(hp);
        build(rd, phy, ra, wd, hp, resp);
        idx = 0;
        @(negedge clk);
        req = 1'b0;
        while (expq.size() > 0) begin
            e = expq.pop_front();
            t = tagq.pop_front();
            chk({t, " busy"}, {31'd0, busy}, 32'd1);
            chk({t, " done"}, {31'd0, done}, 32'd0);
            chk({t, " mdc"}, {31'd0, mdc}, {31'd0, e[3]});
            chk({t, " oe"}, {31'd0, mdio_oe}, {31'd0, e[1]});
            if (e[1]) chk({t, " mdio_o"}, {31'd0, mdio_o}, {31'd0, e[2]});
            chk("R10 rd_data hold", {16'd0, rd_data}, {16'd0, exp_rd});
            mdio_i = e[0];
            if (disturb && idx == 120) begin
                // R9 and R11: request and divisor change while busy
                req = 1'b1; req_read = ~rd; req_phy = 5'h1f; req_reg = 5'h00;
                req_wdata = 16'hffff; half_period = 8'd0;
            end else begin
                req = 1'b0;
                if (disturb) req_phy = 5'h15;
            end
            idx++;
            @(negedge clk);
        end
        req = 1'b0;
        mdio_i = 1'b0;
        if (rd) exp_rd = resp[15:0];
        chk("R8 done pulse", {31'd0, done}, 32'd1);
        chk("R8 busy low at done", {31'd0, busy}, 32'd0);
        chk("R7 rd_data", {16'd0, rd_data}, {16'd0, exp_rd});
        @(negedge clk);
        chk("R8 done one cycle", {31'd0, done}, 32'd0);
        chk("R1 idle line", {29'd0, mdc, mdio_o, mdio_oe}, 32'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset done", {31'd0, done}, 32'd0);
        chk("R1 reset line", {29'd0, mdc, mdio_o, mdio_oe}, 32'd3);
        chk("R1 reset rd_data", {16'd0, rd_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {29'd0, mdc, mdio_o, mdio_oe}, 32'd3);

        txn(1'b0, 5'h01, 5'h1f, 16'hA5C3, 0, 18'h0, 1'b0);
        txn(1'b1, 5'h0a, 5'h02, 16'hBEEF, 1, 18'h31234, 1'b0);
        txn(1'b0, 5'h1e, 5'h11, 16'h5A0F, 2, 18'h0, 1'b0);
        txn(1'b1, 5'h13, 5'h0c, 16'h0000, 3, 18'h2FEDC, 1'b1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R9 no extra transaction", {31'd0, busy}, 32'd0);
        end
        txn(1'b1, 5'h00, 5'h00, 16'h0000, 0, 18'h00001, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule